// File: doc/BRIEF.md
# UART Receive FIFO Idle Time-out Timer

This block watches a UART receive FIFO and raises a pending flag when data has been left unread for four whole character times. Character time is measured in ticks of the 16x receive baud clock, so the delay follows the programmed baud rate. The bit count per character covers data, parity and stop bits, with the second stop bit included when two are programmed. The flag feeds the interrupt identification logic, which ranks it alongside received-data-available.

A three-state machine controls the timer:

- `ST_IDLE`: the FIFO is empty or FIFO mode is off, and the tick counter is held at zero.
- `ST_TIMING`: counting is in progress.
- `ST_PENDING`: the flag is raised.

The transitions are:

- `T_ARM` (IDLE to TIMING): the FIFO is enabled and holds data.
- `T_RESTART` (TIMING to TIMING): a character is received or the CPU reads the FIFO. The counter returns to zero.
- `T_EXPIRE` (TIMING to PENDING): the tick that completes the window arrives.
- `T_SERVICE` (PENDING to TIMING): the CPU reads one character.
- `T_DRAIN` (TIMING or PENDING to IDLE): the FIFO empties or FIFO mode is turned off.

Top module: `uart_rx_timeout`

## Requirements
- R1: When `fifo_mode_en` is low or `fifo_not_empty` is low at a clock edge, `timeout_pending` is low after that edge and the counter is held at zero.
- R2: The window is 64 × N ticks of `baud_tick16`, where N is the effective character bit count (4 characters × 16 ticks per bit). `timeout_pending` rises after the edge that samples the final tick of the window, and not one tick earlier.
- R3: `char_bits` is a 4-bit unsigned count. Values below 7 act as 7 and values above 12 act as 12.
- R4: While no time-out is pending, `rx_char_done` high at an edge returns the count to zero. A tick in that same cycle is not counted.
- R5: While no time-out is pending, `cpu_fifo_read` high at an edge returns the count to zero.
- R6: While a time-out is pending and the FIFO is active, `cpu_fifo_read` clears `timeout_pending` after that edge. A fresh full window then starts.
- R7: While a time-out is pending, `rx_char_done` without a CPU read leaves `timeout_pending` high.
- R8: Clock cycles with `baud_tick16` low do not advance the count.
- R9: After reset `timeout_pending` is low. Counting starts in the cycle after the FIFO becomes active; a tick in the arming cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| char_bits | input | 4 | Bits per character: data, parity and stop bits |
| fifo_mode_en | input | 1 | FIFO mode enabled |
| fifo_not_empty | input | 1 | Receive FIFO holds at least one character |
| rx_char_done | input | 1 | A character has been written into the FIFO |
| cpu_fifo_read | input | 1 | The CPU has read one character from the FIFO |
| timeout_pending | output | 1 | Time-out flag sent to the interrupt logic |

## Verification
The bench targets the exact window length:

- It checks at the tick before expiry and at the tick that completes the window, for 7, 12 and clamped out-of-range bit counts. An off-by-one counter would flag a tick early or late, and missing clamping would give a window of the wrong length.
- It sends a received character while the flag is pending. A design that treats this the same as a read would clear the flag.
- After a CPU read clears the flag, the bench times a full second window. A design that does not zero the counter on that read would expire again almost at once.
- Long stretches without ticks, and drains of the FIFO partway through a window, expose timers that count clock cycles or keep a stale count.

// File: rtl/uart_rx_timeout_pkg.sv
package uart_rx_timeout_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_PENDING = 2'd2
    } rxto_state_t;

endpackage

// File: rtl/rxto_window_calc.sv
// Turns the programmed bit count into the window length in 16x ticks.
module rxto_window_calc #(
    parameter int BITS_W        = 4,
    parameter int MIN_BITS      = 7,
    parameter int MAX_BITS      = 12,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_WINDOW   = 4,
    parameter int LIM_W         = 10
) (
    input  logic [BITS_W-1:0] char_bits,
    output logic [LIM_W-1:0]  window_ticks
);
    localparam logic [BITS_W-1:0] MIN_B = BITS_W'(MIN_BITS);
    localparam logic [BITS_W-1:0] MAX_B = BITS_W'(MAX_BITS);
    localparam logic [LIM_W-1:0]  SCALE = LIM_W'(CHAR_WINDOW * TICKS_PER_BIT);

    logic [BITS_W-1:0] eff_bits;

    always_comb begin
        if (char_bits < MIN_B)      eff_bits = MIN_B;
        else if (char_bits > MAX_B) eff_bits = MAX_B;
        else                        eff_bits = char_bits;
    end

    assign window_ticks = LIM_W'(eff_bits) * SCALE;
endmodule

// File: rtl/rxto_tick_counter.sv
// Counts baud ticks; reports the tick that completes the window.
module rxto_tick_counter #(
    parameter int LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [LIM_W-1:0] window_ticks,
    output logic             window_done
);
    logic [LIM_W-1:0] cnt;
    logic [LIM_W:0]   cnt_inc;

    assign cnt_inc     = {1'b0, cnt} + {{LIM_W{1'b0}}, 1'b1};
    assign window_done = tick && !clr && (cnt_inc >= {1'b0, window_ticks});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt_inc[LIM_W-1:0];
    end

    // R8: the count only moves on a tick
    a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

    // R4: a clear leaves the count at zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/rxto_ctrl_fsm.sv
module rxto_ctrl_fsm
    import uart_rx_timeout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_char,
    input  logic cpu_rd,
    input  logic window_done,
    output logic cnt_clr,
    output logic pending
);
    rxto_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (active) state_nx = ST_TIMING;                 // T_ARM
            ST_TIMING:  if (!active)          state_nx = ST_IDLE;        // T_DRAIN
                        else if (rx_char || cpu_rd) state_nx = ST_TIMING; // T_RESTART
                        else if (window_done) state_nx = ST_PENDING;     // T_EXPIRE
            ST_PENDING: if (!active)    state_nx = ST_IDLE;              // T_DRAIN
                        else if (cpu_rd) state_nx = ST_TIMING;           // T_SERVICE
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == ST_PENDING);
        cnt_clr = (state != ST_TIMING) || !active || rx_char || cpu_rd;
    end

    // R1: inactive FIFO drops the flag
    a_r1_drop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pending);
    // R6: read while pending clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cpu_rd) |=> !pending);
    // R7: received character alone does not clear the flag
    a_r7_rx_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && active && !cpu_rd) |=> pending);
    // R2: the flag rises only on a completing tick
    a_r2_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && (state_nx == ST_PENDING)) |-> window_done);
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
    parameter int BITS_W        = 4,
    parameter int MIN_BITS      = 7,
    parameter int MAX_BITS      = 12,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_WINDOW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic [BITS_W-1:0] char_bits,
    input  logic              fifo_mode_en,
    input  logic              fifo_not_empty,
    input  logic              rx_char_done,
    input  logic              cpu_fifo_read,
    output logic              timeout_pending
);
    localparam int MAX_TICKS = CHAR_WINDOW * TICKS_PER_BIT * MAX_BITS;
    localparam int LIM_W     = $clog2(MAX_TICKS + 1);

    logic [LIM_W-1:0] window_ticks;
    logic             window_done;
    logic             cnt_clr;
    logic             active;

    assign active = fifo_mode_en && fifo_not_empty;

    rxto_window_calc #(
        .BITS_W(BITS_W), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS),
        .TICKS_PER_BIT(TICKS_PER_BIT), .CHAR_WINDOW(CHAR_WINDOW), .LIM_W(LIM_W)
    ) u_calc (
        .char_bits(char_bits),
        .window_ticks(window_ticks)
    );

    rxto_tick_counter #(.LIM_W(LIM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(baud_tick16),
        .window_ticks(window_ticks), .window_done(window_done)
    );

    rxto_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .rx_char(rx_char_done),
        .cpu_rd(cpu_fifo_read), .window_done(window_done),
        .cnt_clr(cnt_clr), .pending(timeout_pending)
    );

    // R9: flag is never raised straight out of an inactive FIFO
    a_r9_no_direct_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_pending && !active) |=> !timeout_pending);
endmodule

// File: tb/sim_uart_rx_timeout.sv
module sim_uart_rx_timeout;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] bits = 4'd7;
    logic       en = 1'b0;
    logic       ne = 1'b0;
    logic       rx = 1'b0;
    logic       rd = 1'b0;
    logic       pend;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_st  = 0;   // 0 idle, 1 timing, 2 pending
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_timeout u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick16(tick), .char_bits(bits),
        .fifo_mode_en(en), .fifo_not_empty(ne), .rx_char_done(rx),
        .cpu_fifo_read(rd), .timeout_pending(pend)
    );

    function automatic int eff_bits(input int b);
        if (b < 7)  return 7;
        if (b > 12) return 12;
        return b;
    endfunction

    function automatic int window_len(input int b);
        return 4 * 16 * eff_bits(b);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else if (!(en && ne)) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_cnt = 0;
        end else if (m_st == 2) begin
            if (rd) begin m_st = 1; m_cnt = 0; end
        end else if (rx || rd) begin
            m_cnt = 0;
        end else if (tick) begin
            m_cnt = m_cnt + 1;
            if (m_cnt >= window_len(int'(bits))) begin m_st = 2; m_cnt = 0; end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle at the negedge, sample at the next negedge
    task automatic step(input logic t, input logic r, input logic d);
        tick = t; rx = r; rd = d;
        @(negedge clk);
        tick = 1'b0; rx = 1'b0; rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic drain;
        ne = 1'b0; step(1'b0, 1'b0, 1'b0); ne = 1'b1;
        step(1'b1, 1'b0, 1'b0);   // arming cycle, tick ignored (R9)
    endtask

    task automatic window_test(input int b, input string tag);
        bits = 4'(b);
        drain();
        ticks(window_len(b) - 1);
        check(pend, 1'b0, {tag, " one tick before window"});
        ticks(1);
        check(pend, 1'b1, {tag, " at window end"});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        @(negedge clk); @(negedge clk);
        check(pend, 1'b0, "R9 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(pend, 1'b0, "R9 after reset release");

        en = 1'b1;
        window_test(7, "R2 7-bit");
        step(1'b1, 1'b1, 1'b0);
        check(pend, 1'b1, "R7 rx char keeps flag");
        step(1'b0, 1'b0, 1'b1);
        check(pend, 1'b0, "R6 read clears flag");
        ticks(447);
        check(pend, 1'b0, "R6 restarted window not done");
        ticks(1);
        check(pend, 1'b1, "R6 full window after service");

        ne = 1'b0; step(1'b1, 1'b0, 1'b0);
        check(pend, 1'b0, "R1 empty FIFO clears flag");
        ticks(1000);
        check(pend, 1'b0, "R1 held while empty");
        ne = 1'b1; en = 1'b0; ticks(1000);
        check(pend, 1'b0, "R1 held while FIFO mode off");
        en = 1'b1;

        window_test(12, "R2 12-bit");
        window_test(2, "R3 clamp low");
        window_test(15, "R3 clamp high");

        bits = 4'd7; drain();
        ticks(300); step(1'b1, 1'b1, 1'b0);
        ticks(447);
        check(pend, 1'b0, "R4 rx restart delays flag");
        ticks(1);
        check(pend, 1'b1, "R4 flag after restarted window");

        drain();
        ticks(400); step(1'b1, 1'b0, 1'b1);
        ticks(447);
        check(pend, 1'b0, "R5 read restart delays flag");
        ticks(1);
        check(pend, 1'b1, "R5 flag after restarted window");

        drain();
        ticks(200);
        for (int i = 0; i < 2000; i++) step(1'b0, 1'b0, 1'b0);
        ticks(247);
        check(pend, 1'b0, "R8 idle cycles not counted");
        ticks(1);
        check(pend, 1'b1, "R8 flag after exact tick count");

        // constrained random against the bench model
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 2999) == 0) ne = ~ne;
            if ($urandom_range(0, 7999) == 0) en = ~en;
            if ($urandom_range(0, 3999) == 0) bits = 4'($urandom_range(0, 15));
            step($urandom_range(0, 3) != 0,
                 $urandom_range(0, 1999) == 0,
                 $urandom_range(0, 1499) == 0);
            check(pend, (m_st == 2), "R1/R2 random model compare");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule